// File: doc/BRIEF.md
# Zero-Voltage Interleaved Gate Synchronizer

This block drives the two gate signals of a two-phase interleaved quasi-resonant boost stage. An outer voltage loop supplies the desired switching period as a count of system clock cycles. Each phase has a comparator flag that goes high when that phase's drain-source voltage has rung down to zero. The block turns each switch on at that zero-voltage moment. It turns the switch off from period timing alone. The second phase's timing trails the first by half a period.

While the output voltage is still below 2.1 times the input, zero-voltage turn-on cannot happen. An upstream start-up flag reports this condition. While the flag is set, the block ignores the comparators and drives both gates as a fixed-period, 50 % duty, antiphase PWM. The default fixed period is 50 kHz at a 100 MHz clock. Mode changes and new period commands take effect only at the end of a phase-1 period, so no gate pulse is ever cut short.

Top module: `zvs_gate_sync`

## Requirements
- R1: While `rst` is high, both gates and both missed flags are low after each clock edge. Start-up mode is selected.
- R2: In start-up mode the timing period is PER_START cycles. With the period counter at n after an edge (0 ≤ n < PER_START), bit 0 of `gate_o` (phase 1) is high when n < PER_START/2, and bit 1 (phase 2) is the inverse of bit 0.
- R3: In start-up mode, the zero-voltage inputs have no effect on either gate.
- R4: `startup_i` is sampled only on the clock edge that ends a phase-1 period. On the edge that enters zero-voltage mode, both gates go low and the counter restarts at 0.
- R5: In zero-voltage mode, a phase's gate goes high only because of a rising edge on that phase's `zv_flag_i` bit. If the flag is first sampled high on clock edge k, the gate is high after edge k+2. A phase turns on at most once per period.
- R6: In zero-voltage mode, phase 1 turns off on the edge that ends its period (counter at P−1 → 0). Phase 2 turns off on the edge where the counter goes from P/2−1 to P/2. Here P is the latched period.
- R7: A period command below PER_MIN is used as PER_MIN, and a command above PER_MAX is used as PER_MAX.
- R8: `period_i` is latched only on the edge that ends a phase-1 period. A change at any other time does not alter the period in force.
- R9: For BLANK_CYC cycles after each turn-off, rising edges on that phase's zero-voltage input are discarded.
- R10: If a phase reaches its turn-off point in zero-voltage mode without having turned on, its bit of `miss_o` is high for exactly one cycle after that edge. In start-up mode, `miss_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Commanded switching period in clock cycles |
| zv_flag_i | input | 2 | Per-phase zero drain-source voltage flag, asynchronous |
| startup_i | input | 1 | High while output voltage is below 2.1 times input |
| gate_o | output | 2 | Gate drive; bit 0 is phase 1, bit 1 is phase 2 |
| miss_o | output | 2 | One-cycle pulse when a phase skipped a whole period |

## Verification
A wrong period counter or latched period shows up as a turn-off edge at the wrong cycle. In zero-voltage mode this is visible within one period. The trailing phase's edge exposes a wrong half-period offset only half a period later. A stuck fired or blanking state appears as a gate that never rises, or one that rises during a blanking window. Either fault is reported by `miss_o` at the next boundary of that phase. A mode register that updates away from the period boundary produces antiphase PWM edges, or all-low gates, at a cycle that is not a multiple of the period.

// File: rtl/zvs_pkg.sv
package zvs_pkg;

    // operating mode of the synchronizer
    typedef enum logic {
        MODE_START = 1'b0,   // fixed-frequency antiphase PWM
        MODE_ZVS   = 1'b1    // zero-voltage-synchronized turn-on
    } mode_e;

    localparam int NUM_PH = 2;

endpackage

// File: rtl/zvs_edge_sync.sv
module zvs_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // one-cycle strobe on a synchronized low-to-high transition
    assign rise_o = st_q.s2 & ~st_q.s3;

endmodule

// File: rtl/zvs_period_timer.sv
module zvs_period_timer
    import zvs_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PER_MIN   = 125,
    parameter int PER_MAX   = 2000,
    parameter int PER_START = 2000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic             startup_i,
    output mode_e            mode_q_o,
    output mode_e            mode_d_o,
    output logic [1:0]       bnd_o,
    output logic [1:0]       pwm_d_o
);
    localparam logic [CNT_W-1:0] MIN_C   = CNT_W'(PER_MIN);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(PER_MAX);
    localparam logic [CNT_W-1:0] START_C = CNT_W'(PER_START);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        mode_e            mode;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] cmd_sat;
    logic [CNT_W-1:0] half_q;
    logic             end_p1;
    logic             end_p2;

    always_comb begin
        // saturate the command into the legal period window
        if (period_i < MIN_C)      cmd_sat = MIN_C;
        else if (period_i > MAX_C) cmd_sat = MAX_C;
        else                       cmd_sat = period_i;

        half_q = st_q.per >> 1;
        end_p1 = (st_q.cnt == st_q.per - ONE_C);
        end_p2 = (st_q.cnt == half_q - ONE_C);

        st_d = st_q;
        if (end_p1) begin
            st_d.cnt  = '0;
            st_d.mode = startup_i ? MODE_START : MODE_ZVS;
            st_d.per  = (st_d.mode == MODE_ZVS) ? cmd_sat : START_C;
        end else begin
            st_d.cnt  = st_q.cnt + ONE_C;
        end

        pwm_d_o[0] = (st_d.cnt < (st_d.per >> 1));
        pwm_d_o[1] = ~pwm_d_o[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt  <= '0;
            st_q.per  <= START_C;
            st_q.mode <= MODE_START;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q_o = st_q.mode;
    assign mode_d_o = st_d.mode;
    assign bnd_o    = {end_p2, end_p1};

endmodule

// File: rtl/zvs_phase_gate.sv
module zvs_phase_gate
    import zvs_pkg::*;
#(
    parameter int BLANK_CYC = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode_q_i,
    input  mode_e mode_d_i,
    input  logic  bnd_i,
    input  logic  pwm_i,
    input  logic  rise_i,
    output logic  gate_o,
    output logic  miss_o
);
    localparam int               BLANK_W = $clog2(BLANK_CYC + 1);
    localparam logic [BLANK_W-1:0] BLANK_C = BLANK_W'(BLANK_CYC);
    localparam logic [BLANK_W-1:0] BONE_C  = BLANK_W'(1);

    typedef struct packed {
        logic               gate;
        logic               fired;
        logic               miss;
        logic [BLANK_W-1:0] blank;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.miss = 1'b0;
        if (mode_d_i == MODE_START) begin
            st_d.gate  = pwm_i;
            st_d.fired = 1'b0;
            st_d.blank = '0;
        end else if (mode_q_i == MODE_START) begin
            // first edge of zero-voltage operation
            st_d.gate  = 1'b0;
            st_d.fired = 1'b0;
            st_d.blank = BLANK_C;
        end else if (bnd_i) begin
            st_d.gate  = 1'b0;
            st_d.miss  = ~st_q.fired;
            st_d.fired = 1'b0;
            st_d.blank = BLANK_C;
        end else if (st_q.blank != '0) begin
            st_d.blank = st_q.blank - BONE_C;
        end else if (rise_i && !st_q.fired) begin
            st_d.gate  = 1'b1;
            st_d.fired = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign gate_o = st_q.gate;
    assign miss_o = st_q.miss;

endmodule

// File: rtl/zvs_gate_sync.sv
module zvs_gate_sync
    import zvs_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int PER_MIN   = 125,
    parameter int PER_MAX   = 2000,
    parameter int PER_START = 2000,
    parameter int BLANK_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [1:0]       zv_flag_i,
    input  logic             startup_i,
    output logic [1:0]       gate_o,
    output logic [1:0]       miss_o
);
    mode_e      mode_q;
    mode_e      mode_d;
    logic [1:0] bnd;
    logic [1:0] pwm_d;
    logic [1:0] rise;

    zvs_period_timer #(
        .CNT_W    (CNT_W),
        .PER_MIN  (PER_MIN),
        .PER_MAX  (PER_MAX),
        .PER_START(PER_START)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .startup_i(startup_i),
        .mode_q_o (mode_q),
        .mode_d_o (mode_d),
        .bnd_o    (bnd),
        .pwm_d_o  (pwm_d)
    );

    for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_phase
        zvs_edge_sync u_sync (
            .clk    (clk),
            .rst    (rst),
            .async_i(zv_flag_i[ph]),
            .rise_o (rise[ph])
        );

        zvs_phase_gate #(
            .BLANK_CYC(BLANK_CYC)
        ) u_gate (
            .clk     (clk),
            .rst     (rst),
            .mode_q_i(mode_q),
            .mode_d_i(mode_d),
            .bnd_i   (bnd[ph]),
            .pwm_i   (pwm_d[ph]),
            .rise_i  (rise[ph]),
            .gate_o  (gate_o[ph]),
            .miss_o  (miss_o[ph])
        );
    end

endmodule

// File: rtl/zvs_gate_sync_chk.sv
module zvs_gate_sync_chk
    import zvs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] zv_flag_i,
    input logic [1:0] gate_o,
    input logic [1:0] miss_o,
    input mode_e      mode_q,
    input logic [1:0] bnd
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (gate_o == 2'b00) && (miss_o == 2'b00));

    // R2
    startup_antiphase_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_START) && !$past(rst) |-> $countones(gate_o) == 1);

    // R10
    startup_nomiss_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_START) |-> miss_o == 2'b00);

    for (genvar ph = 0; ph < NUM_PH; ph++) begin : g_ph
        // R5
        zv_turn_on_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_q == MODE_ZVS) && $rose(gate_o[ph]) |-> $past(zv_flag_i[ph], 3));

        // R6
        timed_turn_off_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_q == MODE_ZVS) && $past(mode_q == MODE_ZVS) && $fell(gate_o[ph])
            |-> $past(bnd[ph]));

        // R10
        miss_single_chk: assert property (@(posedge clk) disable iff (rst)
            miss_o[ph] |=> !miss_o[ph]);
    end

endmodule

bind zvs_gate_sync zvs_gate_sync_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .zv_flag_i(zv_flag_i),
    .gate_o   (gate_o),
    .miss_o   (miss_o),
    .mode_q   (mode_q),
    .bnd      (bnd)
);

// File: tb/zvs_gate_sync_test.sv
module zvs_gate_sync_test;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] period_i = 8'd30;
    logic [1:0]       zv_flag_i = 2'b00;
    logic             startup_i = 1'b1;
    logic [1:0]       gate_o;
    logic [1:0]       miss_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int         at;
        logic [1:0] ge;
        logic [1:0] gm;
        logic [1:0] me;
        logic [1:0] mm;
        string      tag;
    } item_t;

    item_t sb[$];

    zvs_gate_sync #(
        .CNT_W    (CNT_W),
        .PER_MIN  (20),
        .PER_MAX  (60),
        .PER_START(40),
        .BLANK_CYC(3)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .zv_flag_i(zv_flag_i),
        .startup_i(startup_i),
        .gate_o   (gate_o),
        .miss_o   (miss_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic expect_at(input int at, input logic [1:0] ge, input logic [1:0] gm,
                             input logic [1:0] me, input logic [1:0] mm, input string tag);
        item_t it;
        it.at = at; it.ge = ge; it.gm = gm; it.me = me; it.mm = mm; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic at_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: compare outputs against expected items as cycles come due
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at == cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (((gate_o & it.gm) != (it.ge & it.gm)) || ((miss_o & it.mm) != (it.me & it.mm))) begin
                errors++;
                $display("FAIL %s cycle %0d: gate=%b miss=%b expected gate=%b miss=%b (masks %b/%b)",
                         it.tag, cyc, gate_o, miss_o, it.ge, it.me, it.gm, it.mm);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 3000);
        errors++;
        $display("FAIL watchdog: run did not complete, cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // scoreboard contents, in cycle order
        expect_at(0,   2'b00, 2'b11, 2'b00, 2'b11, "R1 reset");
        expect_at(5,   2'b01, 2'b11, 2'b00, 2'b11, "R2 startup first half");
        expect_at(25,  2'b10, 2'b11, 2'b00, 2'b11, "R2 startup second half");
        expect_at(30,  2'b10, 2'b11, 2'b00, 2'b11, "R3 zv ignored in startup");
        expect_at(39,  2'b10, 2'b11, 2'b00, 2'b11, "R2 period end");
        expect_at(40,  2'b01, 2'b11, 2'b00, 2'b11, "R2 period restart");
        expect_at(79,  2'b10, 2'b11, 2'b00, 2'b11, "R4 mode held to boundary");
        expect_at(80,  2'b00, 2'b11, 2'b00, 2'b11, "R4 zvs entry gates low");
        expect_at(86,  2'b00, 2'b01, 2'b00, 2'b00, "R5 turn-on latency early");
        expect_at(87,  2'b01, 2'b01, 2'b00, 2'b00, "R5 turn-on on zv edge");
        expect_at(95,  2'b00, 2'b10, 2'b10, 2'b10, "R10 phase2 missed");
        expect_at(96,  2'b00, 2'b00, 2'b00, 2'b10, "R10 miss one clock");
        expect_at(102, 2'b10, 2'b10, 2'b00, 2'b00, "R5 phase2 turn-on");
        expect_at(109, 2'b01, 2'b01, 2'b00, 2'b00, "R6 phase1 before end");
        expect_at(110, 2'b00, 2'b01, 2'b00, 2'b01, "R6 phase1 turn-off");
        expect_at(124, 2'b10, 2'b10, 2'b00, 2'b00, "R6 phase2 before end");
        expect_at(125, 2'b00, 2'b10, 2'b00, 2'b00, "R6 phase2 half-period offset");
        expect_at(139, 2'b00, 2'b01, 2'b00, 2'b00, "R9 blanked edge ignored");
        expect_at(140, 2'b00, 2'b01, 2'b01, 2'b01, "R9 blanked phase misses");
        expect_at(148, 2'b01, 2'b01, 2'b00, 2'b00, "R5 turn-on after blank");
        expect_at(150, 2'b00, 2'b00, 2'b10, 2'b10, "R8 phase2 boundary new period");
        expect_at(159, 2'b01, 2'b01, 2'b00, 2'b00, "R7 low clamp holds");
        expect_at(160, 2'b00, 2'b01, 2'b00, 2'b00, "R7 low clamp period 20");
        expect_at(180, 2'b01, 2'b01, 2'b00, 2'b01, "R8 period not 20 after latch");
        expect_at(190, 2'b00, 2'b00, 2'b10, 2'b10, "R7 high clamp half 30");
        expect_at(219, 2'b01, 2'b01, 2'b00, 2'b00, "R7 high clamp before end");
        expect_at(220, 2'b01, 2'b11, 2'b00, 2'b11, "R4 back to startup");
        expect_at(240, 2'b10, 2'b11, 2'b00, 2'b11, "R2 startup after return");

        repeat (3) @(negedge clk);
        rst = 1'b0;

        at_cyc(26);  zv_flag_i[0] = 1'b1;
        at_cyc(29);  zv_flag_i[0] = 1'b0;
        at_cyc(60);  startup_i    = 1'b0;
        at_cyc(84);  zv_flag_i[0] = 1'b1;
        at_cyc(99);  zv_flag_i[1] = 1'b1;
        at_cyc(100); zv_flag_i[0] = 1'b0;
        at_cyc(110); zv_flag_i[0] = 1'b1;
        at_cyc(112); zv_flag_i[1] = 1'b0;
        at_cyc(130); period_i     = 8'd5;
        at_cyc(140); zv_flag_i[0] = 1'b0;
        at_cyc(145); zv_flag_i[0] = 1'b1;
        at_cyc(150); period_i     = 8'd200;
        at_cyc(160); zv_flag_i[0] = 1'b0;
        at_cyc(170); zv_flag_i[0] = 1'b1;
        at_cyc(200); startup_i    = 1'b1;
        at_cyc(245);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expected items never compared", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule